// File: doc/BRIEF.md
# DAC Channel Trigger and DMA Request Controller

This block decides when one converter channel's output word is updated. A data word is written into a holding register over a simple register port. A trigger then copies it into the output register that drives the converter. The trigger is either a bit that software sets or a rising edge on one of up to fifteen external trigger lines. A four-bit selector in the control register chooses the trigger source.

When DMA mode is enabled, each external trigger first loads the output and then raises a request to the DMA engine. The request stays high until the engine acknowledges it. Only one request can be outstanding at a time. An external trigger that arrives while a request is still pending sets a sticky underrun flag, leaves the output word unchanged and raises no second request. The underrun flag can drive an interrupt line. Software clears the flag by writing 1 to it.

Top module: `dac_xfer_ctrl`

## Requirements
- R1: After reset the output word, the DMA request, the interrupt, the status register and the control register are all 0.
- R2: If the channel is on (control bit 0) and the selector (control bits 7:4) holds 15, writing 1 to control bit 3 sets a pending software trigger. The output word takes the holding value on the next clock edge, and bit 3 then reads back 0.
- R3: While the channel is on, writes to the selector field are ignored. The other control bits are still written.
- R4: If the channel is on and the selector holds k (k < 15), a rising edge on trigger input k loads the holding value into the output. The load happens on the third rising clock edge after the input goes high. Edges on any other input, and every external edge when the selector is 15 or the channel is off, leave the output unchanged.
- R5: If DMA mode (control bit 1) is on, an accepted external trigger raises the request on the clock edge after the output load.
- R6: The DMA request stays high until the acknowledge input is sampled high. It is low from the next cycle on.
- R7: An external trigger in DMA mode while a request is pending (raised or about to be raised, and not acknowledged in that cycle) sets status bit 0. It does not load the output and adds no request.
- R8: Status bit 0 stays set until a write of 1 to it. Writing 0 leaves it set, and a new underrun in the same cycle wins over the clear.
- R9: The interrupt output is high exactly when status bit 0 is set and the underrun interrupt enable (control bit 2) is set.
- R10: A software-triggered load never raises a DMA request, even with DMA mode on.
- R11: Read address 0 returns control, 1 returns status, 2 returns the holding word and 3 returns the output word, all zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| ext_trig | input | 15 | Asynchronous external trigger lines |
| dma_ack | input | 1 | DMA acknowledge |
| dma_req | output | 1 | DMA request |
| irq | output | 1 | Underrun interrupt |
| dac_out | output | 12 | Output word to the converter |

## Verification
A wrong pending-request state shows up at the next external trigger. Either the output fails to move, with a spurious underrun bit in status, or a trigger that should have been refused loads the output. Both are visible three clock edges after the input edge. A wrong synchroniser depth or edge detector moves the output one cycle early or late, or on the wrong input. The bench sweeps every selector code against every trigger line to catch this. A software trigger bit that is never cleared reads back as 1 one cycle after the write.

// File: rtl/dac_xfer_pkg.sv
package dac_xfer_pkg;
  localparam int SEL_W = 4;
  localparam logic [SEL_W-1:0] SEL_SW = 4'hF;

  localparam int B_CHAN = 0;
  localparam int B_DMA  = 1;
  localparam int B_UIE  = 2;
  localparam int B_SW   = 3;
  localparam int B_SEL  = 4;
  localparam int B_UDR  = 0;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_STAT = 2'd1,
    A_HOLD = 2'd2,
    A_OUT  = 2'd3
  } addr_e;

  typedef struct packed {
    logic             chan_on;
    logic             dma_on;
    logic             udr_ie;
    logic [SEL_W-1:0] sel;
  } cfg_t;
endpackage

// File: rtl/dac_rst_sync.sv
module dac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_n = sh_q[STAGES-1];
endmodule

// File: rtl/dac_trig_sync.sv
module dac_trig_sync #(
  parameter int N      = 15,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] trig_raw,
  output logic [N-1:0] trig_rise
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic [STAGES-1:0] sh_q;
    logic [STAGES-1:0] sh_d;
    logic              last_q;

    always_comb sh_d = {sh_q[STAGES-2:0], trig_raw[i]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q   <= '0;
        last_q <= 1'b0;
      end else begin
        sh_q   <= sh_d;
        last_q <= sh_q[STAGES-1];
      end
    end

    assign trig_rise[i] = sh_q[STAGES-1] & ~last_q;
  end
endmodule

// File: rtl/dac_dma_hs.sv
module dac_dma_hs (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_fire,
  input  logic dma_on,
  input  logic dma_ack,
  input  logic udr_clr,
  output logic load_ok,
  output logic dma_req,
  output logic udr_flag
);
  logic arm_q, arm_d;
  logic req_q, req_d;
  logic udr_q, udr_d;
  logic pending, collide;

  always_comb begin
    pending = arm_q | (req_q & ~dma_ack);
    collide = ext_fire & dma_on & pending;
    load_ok = ext_fire & ~collide;
    arm_d   = ext_fire & dma_on & ~pending;
    if (arm_q)                req_d = 1'b1;
    else if (req_q & dma_ack) req_d = 1'b0;
    else                      req_d = req_q;
    if (collide)      udr_d = 1'b1;
    else if (udr_clr) udr_d = 1'b0;
    else              udr_d = udr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
      req_q <= 1'b0;
      udr_q <= 1'b0;
    end else begin
      arm_q <= arm_d;
      req_q <= req_d;
      udr_q <= udr_d;
    end
  end

  assign dma_req  = req_q;
  assign udr_flag = udr_q;
endmodule

// File: rtl/dac_xfer_ctrl.sv
module dac_xfer_ctrl
  import dac_xfer_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int REG_W  = 32,
  parameter int N_EXT  = 15,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [1:0]        rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic [N_EXT-1:0]  ext_trig,
  input  logic              dma_ack,
  output logic              dma_req,
  output logic              irq,
  output logic [DATA_W-1:0] dac_out
);
  localparam int SEL_N = 1 << SEL_W;

  logic rst_n;
  cfg_t cfg_q, cfg_d;
  logic sw_q, sw_d;
  logic [DATA_W-1:0] hold_q, out_q, out_d;
  logic [N_EXT-1:0]  rise;
  logic [SEL_N-1:0]  rise_pad;
  logic wr_ctrl, wr_hold, sw_set, udr_clr;
  logic ext_fire, sw_fire, load_ok, udr_flag, out_en;
  logic chan_on_w;
  logic [SEL_W-1:0] sel_w;
  logic unused_wr_bits;

  dac_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(arst_n), .rst_n(rst_n)
  );

  dac_trig_sync #(.N(N_EXT), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .trig_raw(ext_trig), .trig_rise(rise)
  );

  always_comb begin
    wr_ctrl  = wr_en && (wr_addr == A_CTRL);
    wr_hold  = wr_en && (wr_addr == A_HOLD);
    sw_set   = wr_ctrl && wr_data[B_SW];
    udr_clr  = wr_en && (wr_addr == A_STAT) && wr_data[B_UDR];
    rise_pad = SEL_N'(rise);
    ext_fire = cfg_q.chan_on && (cfg_q.sel != SEL_SW) && rise_pad[cfg_q.sel];
    sw_fire  = sw_q && cfg_q.chan_on && (cfg_q.sel == SEL_SW);
  end

  dac_dma_hs u_dma (
    .clk(clk), .rst_n(rst_n), .ext_fire(ext_fire), .dma_on(cfg_q.dma_on),
    .dma_ack(dma_ack), .udr_clr(udr_clr), .load_ok(load_ok),
    .dma_req(dma_req), .udr_flag(udr_flag)
  );

  always_comb begin
    cfg_d         = cfg_q;
    cfg_d.chan_on = wr_data[B_CHAN];
    cfg_d.dma_on  = wr_data[B_DMA];
    cfg_d.udr_ie  = wr_data[B_UIE];
    if (!cfg_q.chan_on) cfg_d.sel = wr_data[B_SEL +: SEL_W];
    if (sw_set)       sw_d = 1'b1;
    else if (sw_fire) sw_d = 1'b0;
    else              sw_d = sw_q;
    out_en = sw_fire | load_ok;
    out_d  = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      sw_q   <= 1'b0;
      hold_q <= '0;
      out_q  <= '0;
    end else begin
      if (wr_ctrl) cfg_q  <= cfg_d;
      sw_q <= sw_d;
      if (wr_hold) hold_q <= wr_data[DATA_W-1:0];
      if (out_en)  out_q  <= out_d;
    end
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = REG_W'({cfg_q.sel, sw_q, cfg_q.udr_ie, cfg_q.dma_on, cfg_q.chan_on});
      A_STAT:  rd_data = REG_W'(udr_flag);
      A_HOLD:  rd_data = REG_W'(hold_q);
      default: rd_data = REG_W'(out_q);
    endcase
  end

  assign irq            = udr_flag & cfg_q.udr_ie;
  assign dac_out        = out_q;
  assign chan_on_w      = cfg_q.chan_on;
  assign sel_w          = cfg_q.sel;
  assign unused_wr_bits = ^wr_data[REG_W-1:DATA_W];
endmodule

// File: rtl/dac_xfer_chk.sv
module dac_xfer_chk
  import dac_xfer_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dma_req,
  input logic              dma_ack,
  input logic              irq,
  input logic              udr_flag,
  input logic              udr_clr,
  input logic              sw_q,
  input logic              sw_set,
  input logic              chan_on,
  input logic [SEL_W-1:0]  sel,
  input logic [DATA_W-1:0] dac_out
);
  // R6
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && dma_ack |=> !dma_req);
  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && !dma_ack |=> dma_req);
  // R8
  udr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    udr_flag && !udr_clr |=> udr_flag);
  // R7
  udr_keep_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(udr_flag) |-> $stable(dac_out));
  // R3
  sel_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_on |=> $stable(sel));
  // R2
  sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_q && chan_on && (sel == SEL_SW) && !sw_set |=> !sw_q);
  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> udr_flag);
endmodule

bind dac_xfer_ctrl dac_xfer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .dma_ack(dma_ack), .irq(irq),
  .udr_flag(udr_flag), .udr_clr(udr_clr), .sw_q(sw_q), .sw_set(sw_set),
  .chan_on(chan_on_w), .sel(sel_w), .dac_out(dac_out)
);

// File: tb/dac_xfer_ctrl_tb.sv
module dac_xfer_ctrl_tb;
  localparam int DW = 12;
  localparam int NE = 15;

  logic clk = 1'b0;
  logic arst_n, wr_en, dma_ack;
  logic [1:0] wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic [NE-1:0] ext_trig;
  logic dma_req, irq;
  logic [DW-1:0] dac_out;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dac_xfer_ctrl u_dut (
    .clk(clk), .arst_n(arst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ext_trig(ext_trig), .dma_ack(dma_ack),
    .dma_req(dma_req), .irq(irq), .dac_out(dac_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cv(input bit ch, input bit dm, input bit ie,
                                     input bit sw, input logic [3:0] sel);
    return {24'd0, sel, sw, ie, dm, ch};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic pulse(input int t, output logic [DW-1:0] o2, output logic [DW-1:0] o3,
                       output logic r3, output logic r4);
    @(negedge clk); ext_trig[t] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); o2 = dac_out;
    @(posedge clk);
    @(negedge clk); o3 = dac_out; r3 = dma_req;
    @(posedge clk);
    @(negedge clk); r4 = dma_req; ext_trig[t] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [DW-1:0] o2, o3, prev, hv, exp;
    logic r3, r4;
    arst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    ext_trig = '0; dma_ack = 1'b0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R1 out", 32'(dac_out), 0);
    chk("R1 req", 32'(dma_req), 0);
    chk("R1 irq", 32'(irq), 0);
    rd(2'd1, r); chk("R1 status", r, 0);
    rd(2'd0, r); chk("R1 ctrl", r, 0);

    // R2 software trigger, DMA off
    wr(2'd0, cv(1, 0, 0, 0, 4'hF));
    wr(2'd2, 32'h2B6);
    rd(2'd2, r); chk("R11 hold readback", r, 32'h2B6);
    wr(2'd0, cv(1, 0, 0, 1, 4'hF));
    chk("R2 not before next edge", 32'(dac_out), 0);
    rd(2'd0, r); chk("R2 sw bit pending", 32'(r[3]), 1);
    @(negedge clk);
    chk("R2 loaded", 32'(dac_out), 32'h2B6);
    rd(2'd0, r); chk("R2 sw bit cleared", 32'(r[3]), 0);
    rd(2'd3, r); chk("R11 out readback", r, 32'h2B6);

    // R3 selector lock while on
    wr(2'd0, cv(1, 1, 0, 0, 4'h5));
    rd(2'd0, r);
    chk("R3 sel ignored", 32'(r[7:4]), 32'hF);
    chk("R3 other bit written", 32'(r[1]), 1);
    wr(2'd0, cv(1, 0, 0, 0, 4'hF));

    // R4 channel off: no load
    wr(2'd0, cv(0, 0, 0, 0, 4'h3));
    wr(2'd2, 32'h111);
    pulse(3, o2, o3, r3, r4);
    chk("R4 channel off", 32'(o3), 32'h2B6);

    // R4 sweep: every selector code against every input
    prev = dac_out;
    for (int s = 0; s < 16; s++) begin
      wr(2'd0, cv(0, 0, 0, 0, 4'(s)));
      wr(2'd0, cv(1, 0, 0, 0, 4'(s)));
      for (int t = 0; t < NE; t++) begin
        hv = DW'(s * 16 + t + 1);
        wr(2'd2, 32'(hv));
        exp = (t == s) ? hv : prev;
        pulse(t, o2, o3, r3, r4);
        chk($sformatf("R4 sel=%0d in=%0d", s, t), 32'(o3), 32'(exp));
        if (t == s) chk($sformatf("R4 timing sel=%0d", s), 32'(o2), 32'(prev));
        chk("R5 no request with DMA off", 32'(r4), 0);
        prev = exp;
      end
    end

    // R5 / R7 / R9 DMA path
    wr(2'd0, cv(0, 0, 0, 0, 4'h2));
    wr(2'd0, cv(1, 1, 1, 0, 4'h2));
    wr(2'd2, 32'h5A5);
    pulse(2, o2, o3, r3, r4);
    chk("R5 output loaded", 32'(o3), 32'h5A5);
    chk("R5 request not with load", 32'(r3), 0);
    chk("R5 request after load", 32'(r4), 1);
    wr(2'd2, 32'h3C3);
    pulse(2, o2, o3, r3, r4);
    chk("R7 output kept", 32'(o3), 32'h5A5);
    chk("R6 request still high", 32'(dma_req), 1);
    rd(2'd1, r); chk("R7 underrun flag", r, 1);
    chk("R9 irq enabled", 32'(irq), 1);
    @(negedge clk); dma_ack = 1'b1;
    @(negedge clk); dma_ack = 1'b0;
    chk("R6 request dropped", 32'(dma_req), 0);
    wr(2'd1, 32'h0);
    rd(2'd1, r); chk("R8 write 0 keeps flag", r, 1);
    wr(2'd1, 32'h1);
    rd(2'd1, r); chk("R8 write 1 clears", r, 0);
    chk("R9 irq low after clear", 32'(irq), 0);

    // R9 with interrupt disabled
    wr(2'd0, cv(1, 1, 0, 0, 4'h2));
    pulse(2, o2, o3, r3, r4);
    chk("R5 load of second word", 32'(o3), 32'h3C3);
    pulse(2, o2, o3, r3, r4);
    rd(2'd1, r); chk("R7 flag again", r, 1);
    chk("R9 irq masked", 32'(irq), 0);
    @(negedge clk); dma_ack = 1'b1;
    @(negedge clk); dma_ack = 1'b0;
    wr(2'd1, 32'h1);

    // R10 software trigger with DMA on
    wr(2'd0, cv(0, 1, 0, 0, 4'hF));
    wr(2'd0, cv(1, 1, 0, 0, 4'hF));
    wr(2'd2, 32'h777);
    wr(2'd0, cv(1, 1, 0, 1, 4'hF));
    @(negedge clk);
    chk("R10 sw load", 32'(dac_out), 32'h777);
    repeat (3) @(negedge clk);
    chk("R10 no request", 32'(dma_req), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule